// File: doc/BRIEF.md
# Keypad Autosleep and Autowake Controller

This block decides whether a key-scan controller is running or asleep. While it is running it counts millisecond ticks in which no key is held, and it drops into sleep once that idle count reaches the period chosen by a 3-bit autosleep code. Software can force sleep or wake through a run bit in the configuration write port, and that run bit reads back the current power state. A key press can also wake the block, but only while the autowake bit is set.

Every wake passes through a settling phase. In this phase the analog enable is already high, but scanning must not start yet. When a fixed number of millisecond ticks has elapsed, the block issues a one-cycle scan-ready strobe. A companion flag goes high in the same cycle when the wake was caused by a key. The scanner then rescans and still captures the key that caused the wake. The block never touches the key FIFO, so the FIFO keeps its contents across sleep entry and exit. The autosleep code and the autowake bit are held in this block and are loaded through their own write strobes.

Top module: `keypad_sleep_ctrl`

## Requirements
- R1: After reset, `run_status` and `analog_en` are 1, `scan_ready` and `wake_by_key` are 0, the autosleep code is 7 and autowake is enabled.
- R2: Autosleep code 0 never puts the block to sleep. Codes 1, 2, 3, 4 and 5 give 8192, 4096, 2048, 1024 and 512 ticks. Codes 6 and 7 give 256 ticks. `run_status` goes to 0 after the clock edge that samples the N-th idle `ms_tick` since the count last restarted.
- R3: The idle count restarts on any cycle with `key_down` high, on a configuration write with `cfg_run`=1, and on any autosleep write. No tick is counted on such a cycle.
- R4: A configuration write with `cfg_run`=0 puts the block to sleep at the next edge from any state. It takes priority over a key wake in the same cycle, and it cancels a settling phase without any strobe.
- R5: While asleep, a configuration write with `cfg_run`=1 starts a wake. `run_status` and `analog_en` are 1 from the next edge.
- R6: While asleep with autowake set (`cfg_autowake`=1 at the last configuration write), `key_down` starts a wake at the next edge. With autowake cleared, `key_down` leaves `run_status` at 0.
- R7: After a wake, `scan_ready` pulses for exactly one cycle at the edge that samples the SETTLE_MS-th `ms_tick` after the wake edge. `wake_by_key` is 1 in that same cycle only if a key caused the wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| key_down | input | 1 | High while any key is held |
| asl_wr | input | 1 | Autosleep code write strobe |
| asl_code | input | 3 | Autosleep code to write |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Run bit: 0 forces sleep, 1 forces wake |
| cfg_autowake | input | 1 | Autowake enable bit |
| run_status | output | 1 | 1 while running or settling, 0 asleep (run bit readback) |
| analog_en | output | 1 | Enable for scan current sources |
| scan_ready | output | 1 | One-cycle strobe when settling completes |
| wake_by_key | output | 1 | Marks a scan_ready caused by a key wake |

## Verification
Every result is registered, so a stimulus sampled at an edge is visible on the outputs after that edge. The sleep entry appears after the edge that takes the N-th idle tick. `scan_ready` appears after the edge that takes the SETTLE_MS-th tick following the wake. The bench drives inputs and samples outputs at the falling edge, so each check reads the values produced by the rising edge just before it. Directed phases count ticks to the exact boundary, N-1 and then N, for each autosleep code. A cycle model in the bench tracks every mixed random cycle and compares against it.

// File: rtl/keypad_sleep_ctrl.sv
module keypad_sleep_ctrl #(
  parameter int SETTLE_MS = 2,
  parameter int BASE_MS   = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       key_down,
  input  logic       asl_wr,
  input  logic [2:0] asl_code,
  input  logic       cfg_wr,
  input  logic       cfg_run,
  input  logic       cfg_autowake,
  output logic       run_status,
  output logic       analog_en,
  output logic       scan_ready,
  output logic       wake_by_key
);
  localparam int MAX_MS = BASE_MS << 5;
  localparam int CNT_W  = $clog2(MAX_MS + 1);
  localparam int ST_W   = $clog2(SETTLE_MS + 1);

  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_SETTLE} pwr_t;

  pwr_t             state;
  logic [2:0]       code_q;
  logic             aw_q;
  logic             key_wake_q;
  logic [CNT_W-1:0] idle_cnt;
  logic [ST_W-1:0]  settle_cnt;
  logic [CNT_W-1:0] limit;

  function automatic logic [CNT_W-1:0] period(input logic [2:0] c);
    if (c == 3'd0)      return '0;
    else if (c >= 3'd6) return CNT_W'(BASE_MS);
    else                return CNT_W'(BASE_MS << (6 - int'(c)));
  endfunction

  assign limit      = period(code_q);
  assign run_status = (state != S_SLEEP);
  assign analog_en  = (state != S_SLEEP);

  wire idle_restart = key_down || (cfg_wr && cfg_run) || asl_wr;
  wire force_sleep  = cfg_wr && !cfg_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_RUN;
      code_q      <= 3'd7;
      aw_q        <= 1'b1;
      key_wake_q  <= 1'b0;
      idle_cnt    <= '0;
      settle_cnt  <= '0;
      scan_ready  <= 1'b0;
      wake_by_key <= 1'b0;
    end else begin
      scan_ready  <= 1'b0;
      wake_by_key <= 1'b0;
      if (asl_wr) code_q <= asl_code;
      if (cfg_wr) aw_q <= cfg_autowake;
      unique case (state)
        S_RUN: begin
          if (force_sleep) begin
            state    <= S_SLEEP;
            idle_cnt <= '0;
          end else if (idle_restart) begin
            idle_cnt <= '0;
          end else if (ms_tick && code_q != 3'd0) begin
            if (idle_cnt == limit - 1'b1) begin
              state    <= S_SLEEP;
              idle_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
        end
        S_SLEEP: begin
          if (cfg_wr) begin
            if (cfg_run) begin
              state      <= S_SETTLE;
              settle_cnt <= '0;
              key_wake_q <= 1'b0;
            end
          end else if (key_down && aw_q) begin
            state      <= S_SETTLE;
            settle_cnt <= '0;
            key_wake_q <= 1'b1;
          end
        end
        S_SETTLE: begin
          if (force_sleep) begin
            state <= S_SLEEP;
          end else if (ms_tick) begin
            if (settle_cnt == ST_W'(SETTLE_MS - 1)) begin
              state       <= S_RUN;
              idle_cnt    <= '0;
              scan_ready  <= 1'b1;
              wake_by_key <= key_wake_q;
            end else begin
              settle_cnt <= settle_cnt + 1'b1;
            end
          end
        end
        default: state <= S_RUN;
      endcase
    end
  end

  // R4
  sleep_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_run |=> !run_status);

  // R5
  wake_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_run |=> run_status);

  // R6
  no_autowake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_status && !cfg_wr && !aw_q |=> !run_status);

  // R2
  no_autosleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_status && code_q == 3'd0 && !cfg_wr && !asl_wr |=> run_status);

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_ready |=> !scan_ready);

  // R7
  strobe_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_ready |-> run_status && analog_en);

  // R7
  key_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_by_key |-> scan_ready);
endmodule

// File: tb/keypad_sleep_ctrl_tb.sv
module keypad_sleep_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, key_down = 1'b0, asl_wr = 1'b0, cfg_wr = 1'b0;
  logic cfg_run = 1'b1, cfg_autowake = 1'b1;
  logic [2:0] asl_code = 3'd0;
  logic run_status, analog_en, scan_ready, wake_by_key;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_sleep_ctrl #(.SETTLE_MS(SETTLE), .BASE_MS(256)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .key_down(key_down),
    .asl_wr(asl_wr), .asl_code(asl_code), .cfg_wr(cfg_wr), .cfg_run(cfg_run),
    .cfg_autowake(cfg_autowake), .run_status(run_status), .analog_en(analog_en),
    .scan_ready(scan_ready), .wake_by_key(wake_by_key));

  function automatic int ticks_for(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 8192;
      3'd2: return 4096;
      3'd3: return 2048;
      3'd4: return 1024;
      3'd5: return 512;
      default: return 256;
    endcase
  endfunction

  // reference model: 0 run, 1 asleep, 2 settling
  int m_st, m_idle, m_set;
  logic [2:0] m_code;
  logic m_aw, m_kw, m_sr, m_wk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_idle <= 0; m_set <= 0; m_code <= 3'd7;
      m_aw <= 1'b1; m_kw <= 1'b0; m_sr <= 1'b0; m_wk <= 1'b0;
    end else begin
      m_sr <= 1'b0; m_wk <= 1'b0;
      if (asl_wr) m_code <= asl_code;
      if (cfg_wr) m_aw <= cfg_autowake;
      if (cfg_wr && !cfg_run) m_st <= 1;
      else if (m_st == 0) begin
        if (key_down || cfg_wr || asl_wr) m_idle <= 0;
        else if (ms_tick && ticks_for(m_code) != 0) begin
          if (m_idle + 1 >= ticks_for(m_code)) begin m_st <= 1; m_idle <= 0; end
          else m_idle <= m_idle + 1;
        end
      end else if (m_st == 1) begin
        if (cfg_wr) begin m_st <= 2; m_set <= 0; m_kw <= 1'b0; end
        else if (key_down && m_aw) begin m_st <= 2; m_set <= 0; m_kw <= 1'b1; end
      end else if (ms_tick) begin
        if (m_set + 1 >= SETTLE) begin
          m_st <= 0; m_idle <= 0; m_sr <= 1'b1; m_wk <= m_kw;
        end else m_set <= m_set + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " run_status"}, run_status, m_st != 1);
    chk({tag, " analog_en"}, analog_en, m_st != 1);
    chk({tag, " scan_ready"}, scan_ready, m_sr);
    chk({tag, " wake_by_key"}, wake_by_key, m_wk);
  endtask

  task automatic cfg(input logic run, input logic aw, input string tag);
    cfg_wr = 1'b1; cfg_run = run; cfg_autowake = aw;
    step(tag);
    cfg_wr = 1'b0;
  endtask

  task automatic set_code(input logic [2:0] c, input string tag);
    asl_wr = 1'b1; asl_code = c;
    step(tag);
    asl_wr = 1'b0;
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 run_status", run_status, 1'b1);
    chk("R1 analog_en", analog_en, 1'b1);
    chk("R1 scan_ready", scan_ready, 1'b0);
    chk("R1 wake_by_key", wake_by_key, 1'b0);

    // R1/R2 default code 7 gives 256 ticks
    ms_tick = 1'b1;
    steps(255, "R1 default period");
    chk("R2 awake at 255", run_status, 1'b1);
    step("R2");
    chk("R2 asleep at 256", run_status, 1'b0);

    // R6/R7 key wake with settling
    key_down = 1'b1;
    step("R6 key wake");
    chk("R6 woke", run_status, 1'b1);
    key_down = 1'b0;
    step("R7");
    chk("R7 no strobe early", scan_ready, 1'b0);
    step("R7");
    chk("R7 strobe", scan_ready, 1'b1);
    chk("R7 key flag", wake_by_key, 1'b1);
    step("R7");
    chk("R7 strobe one cycle", scan_ready, 1'b0);

    // R4 force sleep, autowake off; R6 key ignored
    cfg(1'b0, 1'b0, "R4");
    chk("R4 asleep", run_status, 1'b0);
    key_down = 1'b1;
    steps(5, "R6 no autowake");
    chk("R6 key ignored", run_status, 1'b0);

    // R5 software wake, R7 flag low
    cfg(1'b1, 1'b1, "R5");
    chk("R5 awake", run_status, 1'b1);
    chk("R5 analog on", analog_en, 1'b1);
    key_down = 1'b0;
    step("R7");
    step("R7");
    chk("R7 soft strobe", scan_ready, 1'b1);
    chk("R7 soft flag", wake_by_key, 1'b0);

    // R3 key restart of idle count, code 6
    set_code(3'd6, "R3");
    steps(200, "R3");
    key_down = 1'b1; step("R3"); key_down = 1'b0;
    steps(255, "R3");
    chk("R3 restart kept awake", run_status, 1'b1);
    step("R3");
    chk("R3 asleep after 256", run_status, 1'b0);

    // R2 each power-of-two code
    for (int c = 1; c <= 5; c++) begin
      cfg(1'b1, 1'b1, "R2 wake");
      steps(SETTLE, "R2 settle");
      set_code(3'(c), "R2 code");
      steps(ticks_for(3'(c)) - 1, "R2");
      chk("R2 awake at N-1", run_status, 1'b1);
      step("R2");
      chk("R2 asleep at N", run_status, 1'b0);
    end

    // R2 code 0 never sleeps
    cfg(1'b1, 1'b1, "R2 wake");
    set_code(3'd0, "R2 code0");
    steps(9000, "R2 code0");
    chk("R2 code 0 stays awake", run_status, 1'b1);

    // R4 priority over key wake, and cancelling settle
    cfg(1'b0, 1'b1, "R4");
    key_down = 1'b1;
    cfg(1'b0, 1'b1, "R4 priority");
    chk("R4 priority over key", run_status, 1'b0);
    step("R4 key wake");
    key_down = 1'b0;
    cfg(1'b0, 1'b1, "R4 cancel");
    chk("R4 cancel settle", run_status, 1'b0);
    steps(4, "R4 no strobe");
    chk("R4 no strobe after cancel", scan_ready, 1'b0);

    // mixed random run against model
    set_code(3'd7, "R3 random");
    for (int i = 0; i < 20000; i++) begin
      ms_tick  = ($urandom % 2) == 0;
      if (($urandom % 16) == 0) key_down = ~key_down;
      cfg_wr   = ($urandom % 300) == 0;
      cfg_run  = $urandom % 2;
      cfg_autowake = ($urandom % 4) != 0;
      asl_wr   = ($urandom % 400) == 0;
      asl_code = ($urandom % 2) ? 3'd6 : 3'($urandom % 8);
      step("R3 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule